// File: doc/BRIEF.md
# Multichannel PCM Serial Audio Transmitter

This block turns a stream of 32-bit memory words into a serial audio signal. It runs on the master audio clock. From that clock it divides down a bit clock, and it drives a left/right word-select line and up to `MAX_PAIRS` serial data lanes, with one stereo pair on each lane. Three framings can be selected: I2S, left-justified and right-justified. A subframe is 16 or 32 bits wide. In 32-bit subframes the valid sample width can be cut to 24 bits.

Words arrive on a valid/ready stream. A word is accepted on any rising clock edge where `s_valid` and `s_ready` are both high. The producer holds `s_data` stable while `s_valid` is high and `s_ready` is low. `s_ready` drops once the words for the next frame are staged, so back-pressure lasts until the following frame boundary. Words may be staged while `run` is low, which lets a producer preload the first frame before starting. Configuration inputs are sampled live and must only change while `run` is low.

Top module: `pcm_serial_tx`

## Requirements
- R1: While running, `sclk` is high for `clk_div` master clock cycles and then low for `clk_div` cycles. A `clk_div` of 0 acts as 1.
- R2: A frame has 64 bit clocks when `wide_slot`=1 and 32 when it is 0, in two equal subframes with the left subframe first. Data goes out MSB first. `sd` and `ws` change only at a falling edge of `sclk`, so a receiver samples them on the rising edge.
- R3: `frame_mode`=0 selects I2S. `ws` is low for the left subframe and high for the right one, and each `ws` change comes one bit clock before the MSB of its subframe. Samples are left-aligned.
- R4: `frame_mode`=1 selects left-justified, and `frame_mode`=3 behaves the same way. `ws` is high during the left subframe, and the sample MSB is on the first bit of the subframe. Bits after the sample width are 0.
- R5: `frame_mode`=2 selects right-justified. `ws` is high during the left subframe. The sample LSB is on the last bit of the subframe, and the leading bits are 0.
- R6: When `wide_slot`=1 and `narrow_data`=1, only bits 31..8 of each sample are sent. The 8 unused bit positions are 0: they are at the end of the subframe for left-aligned modes and at the start for right-justified.
- R7: When `packed_mem`=1, each stream word feeds one lane. Bits 31..16 are the left sample and bits 15..0 are the right sample, each sent as if it were left-aligned in a 32-bit word. When `packed_mem`=0, each lane takes two words: a 32-bit left-aligned left sample, then the right sample.
- R8: `pair_count` (1 to `MAX_PAIRS`; 0 acts as 1, larger values act as `MAX_PAIRS`) sets the number of active lanes. Lane k is `sd[k]`. Stream words are taken for lane 0 first and then in increasing lane order. Lanes at index `pair_count` and above stay 0.
- R9: `s_ready` is high while fewer words are staged than one frame needs (`pair_count` words if packed, twice that otherwise), except in the cycle where a frame is loaded. Once the staging is full, `s_ready` stays low until the next frame boundary.
- R10: If a frame boundary arrives while running and the staging is not full, the whole frame is sent as zeros, `underflow` is high for exactly one cycle, and any words that were partly staged are discarded.
- R11: After reset, and on the cycle after `run` is low, `sclk`, `ws`, `sd` and `underflow` are 0. When `run` rises, the first bit sent is the MSB slot of the left subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| run | input | 1 | 1 = transmit, 0 = hold serial side idle |
| frame_mode | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| wide_slot | input | 1 | 1 = 32-bit subframes, 0 = 16-bit |
| narrow_data | input | 1 | With wide_slot, send 24 valid bits |
| packed_mem | input | 1 | 1 = two 16-bit samples per word |
| pair_count | input | PAIR_W | Number of active stereo lanes |
| clk_div | input | DIV_W | Half bit-clock period in master cycles |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with s_valid |
| s_data | input | 32 | Stream word |
| sclk | output | 1 | Bit clock |
| ws | output | 1 | Left/right word select |
| sd | output | MAX_PAIRS | Serial data, one lane per stereo pair |
| underflow | output | 1 | One-cycle pulse on a starved frame |

## Verification
The bench builds the block with its default parameters, `MAX_PAIRS`=5 and `DIV_W`=8. With these values it can drive all five lanes at once in packed mode and see lanes left idle when fewer pairs are selected. It can also run divider ratios of 1, 2 and 3, so the half-period timing is measured at a ratio above one. Each case preloads a frame, streams random samples for several frames and then starves the block. This covers every framing, both subframe widths, the 24-bit cut and both memory packings.

// File: rtl/pcm_serial_tx_pkg.sv
package pcm_serial_tx_pkg;
  localparam int WORD_W = 32;
  typedef enum logic [1:0] {
    FRM_I2S   = 2'd0,
    FRM_LEFT  = 2'd1,
    FRM_RIGHT = 2'd2,
    FRM_ALT   = 2'd3
  } frame_mode_e;
endpackage

// File: rtl/pcm_tx_bitclk.sv
module pcm_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] clk_div,
  output logic             sclk,
  output logic             fall_stb
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;
  logic             tick;

  assign div_eff  = (clk_div == '0) ? ONE : clk_div;
  assign tick     = en && (cnt_q >= div_eff - ONE);
  assign fall_stb = tick && sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk); // R11
endmodule

// File: rtl/pcm_tx_stage.sv
module pcm_tx_stage #(
  parameter int MAX_PAIRS = 5,
  parameter int PAIR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              packed_mem,
  input  logic [PAIR_W-1:0] npairs,
  input  logic              take,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [31:0]       s_data,
  output logic              full,
  output logic [31:0]       stg [2*MAX_PAIRS]
);
  localparam int CNT_W = PAIR_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] needed;

  assign needed  = packed_mem ? {1'b0, npairs} : {npairs, 1'b0};
  assign full    = (cnt_q == needed);
  assign s_ready = (cnt_q < needed) && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < 2*MAX_PAIRS; i++) stg[i] <= '0;
    end else if (take) begin
      cnt_q <= '0;
    end else if (s_valid && s_ready) begin
      stg[cnt_q] <= s_data;
      cnt_q      <= cnt_q + CNT_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= needed); // R9
endmodule

// File: rtl/pcm_tx_frame.sv
module pcm_tx_frame
  import pcm_serial_tx_pkg::*;
#(
  parameter int MAX_PAIRS = 5,
  parameter int PAIR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 fall,
  input  logic                 sclk,
  input  logic [1:0]           frame_mode,
  input  logic                 wide_slot,
  input  logic                 narrow_data,
  input  logic                 packed_mem,
  input  logic [PAIR_W-1:0]    npairs,
  input  logic                 full,
  input  logic [31:0]          stg [2*MAX_PAIRS],
  output logic                 active,
  output logic                 load,
  output logic                 underflow,
  output logic                 ws,
  output logic [MAX_PAIRS-1:0] sd
);
  frame_mode_e mode;
  logic [5:0]  bit_q, sb, fb_last, dw, off, pos, idx, nxt;
  logic        upper;

  assign mode    = frame_mode_e'(frame_mode);
  assign sb      = wide_slot ? 6'd32 : 6'd16;
  assign fb_last = wide_slot ? 6'd63 : 6'd31;
  assign dw      = wide_slot ? (narrow_data ? 6'd24 : 6'd32) : 6'd16;
  assign off     = (mode == FRM_RIGHT) ? (sb - dw) : 6'd0;
  assign upper   = (bit_q >= sb);
  assign pos     = upper ? (bit_q - sb) : bit_q;
  assign idx     = 6'd31 - (pos - off);
  assign nxt     = (bit_q == fb_last) ? 6'd0 : bit_q + 6'd1;
  assign load    = run && (!active || (fall && bit_q == fb_last));

  always_comb begin
    if (mode == FRM_I2S) ws = active && (nxt >= sb);
    else                 ws = active && (bit_q < sb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bit_q     <= '0;
      underflow <= 1'b0;
    end else begin
      active    <= run;
      underflow <= load && active && !full;
      if (!run)      bit_q <= '0;
      else if (load) bit_q <= '0;
      else if (fall) bit_q <= bit_q + 6'd1;
    end
  end

  for (genvar l = 0; l < MAX_PAIRS; l++) begin : g_lane
    logic [31:0] l_new, r_new, l_q, r_q, v;
    always_comb begin
      if (packed_mem) begin
        l_new = {stg[l][31:16], 16'h0};
        r_new = {stg[l][15:0], 16'h0};
      end else begin
        l_new = stg[2*l];
        r_new = stg[2*l+1];
      end
      if (wide_slot && narrow_data) begin
        l_new[7:0] = 8'h0;
        r_new[7:0] = 8'h0;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        l_q <= '0;
        r_q <= '0;
      end else if (load) begin
        l_q <= full ? l_new : '0;
        r_q <= full ? r_new : '0;
      end
    end
    assign v     = upper ? r_q : l_q;
    assign sd[l] = active && (npairs > PAIR_W'(l)) && (pos >= off) && v[idx[4:0]];
  end

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sd != $past(sd)) |-> $fell(sclk)); // R2
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && ws != $past(ws)) |-> $fell(sclk)); // R3
  AST_UNF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ws && sd == '0 && !underflow)); // R11
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int MAX_PAIRS = 5,
  parameter int DIV_W     = 8,
  parameter int PAIR_W    = $clog2(MAX_PAIRS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [1:0]           frame_mode,
  input  logic                 wide_slot,
  input  logic                 narrow_data,
  input  logic                 packed_mem,
  input  logic [PAIR_W-1:0]    pair_count,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [31:0]          s_data,
  output logic                 sclk,
  output logic                 ws,
  output logic [MAX_PAIRS-1:0] sd,
  output logic                 underflow
);
  localparam logic [PAIR_W-1:0] PAIR_MAX = PAIR_W'(MAX_PAIRS);

  logic [PAIR_W-1:0] npairs;
  logic              active, load, fall, full;
  logic [31:0]       stg [2*MAX_PAIRS];

  assign npairs = (pair_count == '0)      ? PAIR_W'(1) :
                  (pair_count > PAIR_MAX) ? PAIR_MAX   : pair_count;

  pcm_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .en(active && run), .clk_div(clk_div),
    .sclk(sclk), .fall_stb(fall)
  );

  pcm_tx_stage #(.MAX_PAIRS(MAX_PAIRS), .PAIR_W(PAIR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .packed_mem(packed_mem), .npairs(npairs),
    .take(load), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .full(full), .stg(stg)
  );

  pcm_tx_frame #(.MAX_PAIRS(MAX_PAIRS), .PAIR_W(PAIR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .fall(fall), .sclk(sclk),
    .frame_mode(frame_mode), .wide_slot(wide_slot), .narrow_data(narrow_data),
    .packed_mem(packed_mem), .npairs(npairs), .full(full), .stg(stg),
    .active(active), .load(load), .underflow(underflow), .ws(ws), .sd(sd)
  );
endmodule

// File: tb/pcm_serial_tx_tb.sv
module pcm_serial_tx_tb;
  localparam int MP = 5;
  localparam int PW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run, wide, narrow, pk, s_valid, s_ready, sclk, ws, underflow;
  logic [1:0] mode;
  logic [PW-1:0] pairs;
  logic [DW-1:0] div;
  logic [31:0] s_data;
  logic [MP-1:0] sd;

  pcm_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .frame_mode(mode), .wide_slot(wide),
    .narrow_data(narrow), .packed_mem(pk), .pair_count(pairs), .clk_div(div),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .sclk(sclk),
    .ws(ws), .sd(sd), .underflow(underflow)
  );

  typedef struct packed {
    logic last;
    logic zero;
    logic [MP-1:0][31:0] l;
    logic [MP-1:0][31:0] r;
  } fr_t;

  fr_t exp_q[$];
  int n_chk = 0, n_fail = 0, unf_cnt = 0, mb = 0;
  logic [31:0] seed = 32'h1234_5678;
  string ws_tag, sd_tag;
  logic [63:0] ws_v;
  logic [MP-1:0][63:0] sd_v;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Expected subframe bits, right-aligned in 32 bits, MSB of slot at sb-1
  function automatic logic [31:0] slot_bits(input logic [31:0] v);
    int sbv, dwv;
    logic [31:0] d;
    sbv = wide ? 32 : 16;
    dwv = wide ? (narrow ? 24 : 32) : 16;
    d = v >> (32 - dwv);
    if (mode == 2'd2) return d;
    return d << (sbv - dwv);
  endfunction

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic feed(input int nframes);
    for (int f = 0; f < nframes; f++) begin
      fr_t e;
      logic [31:0] words[$];
      e = '0;
      for (int l = 0; l < pairs; l++) begin
        logic [31:0] a, b;
        a = rnd();
        b = rnd();
        if (pk) begin
          e.l[l] = {a[31:16], 16'h0};
          e.r[l] = {a[15:0], 16'h0};
          words.push_back(a);
        end else begin
          e.l[l] = a;
          e.r[l] = b;
          words.push_back(a);
          words.push_back(b);
        end
      end
      exp_q.push_back(e);
      foreach (words[i]) send_word(words[i]);
    end
    begin
      fr_t z;
      z = '0;
      z.zero = 1'b1;
      z.last = 1'b1;
      exp_q.push_back(z);
    end
  endtask

  // Monitor: decode one frame per fb rising bit-clock edges, compare to scoreboard
  always begin
    @(posedge sclk);
    #1;
    if (run) begin
      int fb, sbv;
      fb  = wide ? 64 : 32;
      sbv = wide ? 32 : 16;
      if (mb == 0) begin
        ws_v = '0;
        sd_v = '0;
      end
      ws_v[mb] = ws;
      for (int l = 0; l < MP; l++) sd_v[l][mb] = sd[l];
      mb++;
      if (mb == fb) begin
        mb = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected frame", ws_v, '0);
        end else begin
          fr_t e;
          logic [63:0] ews;
          e = exp_q.pop_front();
          ews = '0;
          for (int b = 0; b < fb; b++) begin
            bit left;
            left = (mode == 2'd0) ? (((b + 1) % fb) < sbv) : (b < sbv);
            ews[b] = (mode == 2'd0) ? !left : left;
          end
          check(ws_v == ews, ws_tag, "word select", ws_v, ews);
          for (int l = 0; l < MP; l++) begin
            logic [63:0] esd;
            esd = '0;
            for (int b = 0; b < fb; b++) begin
              int p;
              logic [31:0] sub;
              p   = (b >= sbv) ? b - sbv : b;
              sub = slot_bits((b >= sbv) ? e.r[l] : e.l[l]);
              esd[b] = (l < pairs && !e.zero) ? sub[sbv - 1 - p] : 1'b0;
            end
            check(sd_v[l] == esd, e.zero ? "R10" : (l >= pairs ? "R8" : sd_tag),
                  $sformatf("lane %0d data", l), sd_v[l], esd);
          end
          if (e.last) run = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) if (underflow) unf_cnt++;

  task automatic do_case(input logic [1:0] m, input logic w, input logic n,
                         input logic p, input int np, input int d, input int nf,
                         input string wt, input string st, input bit meas);
    @(negedge clk);
    mode = m; wide = w; narrow = n; pk = p; pairs = PW'(np); div = DW'(d);
    ws_tag = wt; sd_tag = st; unf_cnt = 0; mb = 0;
    fork feed(nf); join_none
    repeat (2) @(negedge clk);
    while (s_ready) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(!s_ready, "R9", "ready while staging full", 64'(s_ready), 64'd0);
    end
    run = 1'b1;
    if (meas) begin
      time t0, t1, t2;
      @(posedge sclk); t0 = $time;
      @(negedge sclk); t1 = $time;
      @(posedge sclk); t2 = $time;
      check((t1 - t0) == d * 20, "R1", "sclk high time", 64'(t1 - t0), 64'(d * 20));
      check((t2 - t0) == 2 * d * 20, "R1", "sclk period", 64'(t2 - t0), 64'(2 * d * 20));
    end
    wait (run == 1'b0);
    repeat (3) @(negedge clk);
    check(!sclk && !ws && sd == '0 && !underflow, "R11", "idle outputs",
          {sclk, ws, underflow, sd}, 64'd0);
    check(unf_cnt == 1, "R10", "underflow pulses", 64'(unf_cnt), 64'd1);
    check(exp_q.size() == 0, "R2", "frames left", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; mode = 2'd0; wide = 1'b0; narrow = 1'b0; pk = 1'b0;
    pairs = PW'(1); div = DW'(1); s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !ws && sd == '0 && !underflow, "R11", "reset outputs",
          {sclk, ws, underflow, sd}, 64'd0);
    check(s_ready, "R9", "ready after reset", 64'(s_ready), 64'd1);

    do_case(2'd0, 1'b0, 1'b0, 1'b0, 2, 1, 3, "R3", "R2", 1'b0);
    do_case(2'd1, 1'b1, 1'b0, 1'b1, 5, 1, 2, "R4", "R7", 1'b0);
    do_case(2'd2, 1'b1, 1'b1, 1'b0, 1, 2, 2, "R5", "R6", 1'b0);
    do_case(2'd1, 1'b1, 1'b1, 1'b0, 2, 1, 2, "R4", "R6", 1'b0);
    do_case(2'd1, 1'b0, 1'b0, 1'b0, 3, 1, 2, "R4", "R8", 1'b0);
    do_case(2'd0, 1'b1, 1'b0, 1'b0, 1, 3, 2, "R3", "R2", 1'b1);
    do_case(2'd2, 1'b0, 1'b0, 1'b1, 2, 1, 2, "R5", "R7", 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule